// File: doc/BRIEF.md
# Per-Pin Trigger and Delivery Controller

This block sits between a set of interrupt input pins and a downstream message port. Each pin has a programmable routing entry: vector, destination, delivery mode, trigger kind (edge or level) and a mask. An agent reports each change on a pin as a per-pin update strobe that carries the new level. The block keeps one pending bit per pin and decides when to put a delivery request on the output port. The request carries the pin's vector, destination, mode and trigger kind.

Level pins are gated by a remote-pending bit. That bit is set when the downstream side accepts a level request. It is cleared only by an end-of-interrupt notification whose vector matches the entry. If the pin is still pending and unmasked when the bit clears, the block requests the pin again. An edge assertion on a pin that is already pending is not delivered a second time. The block instead raises a coalesced pulse for that pin in the same cycle. Downstream acceptance is modelled as a ready strobe plus an "accepted by at least one destination" flag, both sampled at the handshake.

Top module: `pin_trigger_ctrl`

## Requirements
- R1: After reset every entry is masked and has edge trigger, and the pending, remote-pending and delivered bitmaps are all zero. No request is raised, and an assertion on a pin that has not been configured produces no request.
- R2: An update strobe with level 0 clears the pin's pending bit at the next clock edge and withdraws any service attempt not yet handed over.
- R3: An edge-trigger assertion on a pin whose pending bit is clear sets the bit, and a request for the pin appears one cycle later. An edge assertion on a pin whose pending bit is already set raises `coalesced[pin]` in the same cycle and starts no new request.
- R4: No request is presented for a masked pin, nor for a level-trigger pin whose remote-pending bit is set. Such an attempt is discarded and is not retried when the condition later lifts.
- R5: When a level-trigger request is handed over (`reqValid` and `reqReady`) with `reqAccepted` high, the pin's remote-pending bit is set. With `reqAccepted` low the bit stays clear.
- R6: An end-of-interrupt strobe clears the remote-pending bit of every level-trigger entry whose vector equals the strobe's vector. Edge entries and entries with other vectors are unaffected.
- R7: If a pin cleared by R6 is unmasked and its pending bit is set, a new request for it follows one cycle after the end-of-interrupt strobe. If the pending bit is clear, no request follows.
- R8: A configuration write that sets level trigger on a pin whose pending bit is set starts a delivery attempt. A write that sets edge trigger clears the pin's remote-pending bit.
- R9: An edge-trigger handover sets the pin's bit in the delivered bitmap. A later edge assertion on that pin clears the bit, including an assertion that is reported as coalesced.
- R10: When several pins are eligible at once, the lowest index is presented first and one pin is handed over per cycle. A presented request remains asserted until `reqReady` is seen.
- R11: The request payload equals the configured entry of the pin named on `reqPin`: vector, destination, mode, and `reqLevel` (1 = level trigger).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineUpd | input | NUM_PINS | Per-pin update strobe |
| lineVal | input | NUM_PINS | New pin level, valid with `lineUpd` |
| cfgWe | input | 1 | Entry write strobe |
| cfgIdx | input | IDX_W | Entry index for the write |
| cfgVector | input | VEC_W | Vector to store |
| cfgDest | input | DEST_W | Destination to store |
| cfgMode | input | MODE_W | Delivery mode to store |
| cfgLevel | input | 1 | Trigger kind to store, 1 = level, 0 = edge |
| cfgMask | input | 1 | Mask bit to store, 1 = masked |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | VEC_W | Vector carried by the end-of-interrupt |
| reqValid | output | 1 | Delivery request present |
| reqReady | input | 1 | Downstream takes the request this cycle |
| reqAccepted | input | 1 | At least one destination accepted, sampled with `reqReady` |
| reqPin | output | IDX_W | Pin index of the request |
| reqVector | output | VEC_W | Vector of the request |
| reqDest | output | DEST_W | Destination of the request |
| reqMode | output | MODE_W | Delivery mode of the request |
| reqLevel | output | 1 | Trigger kind of the request |
| coalesced | output | NUM_PINS | One-cycle pulse: edge assertion merged into a pending one |
| irrBits | output | NUM_PINS | Pending bit per pin |
| remoteBits | output | NUM_PINS | Remote-pending bit per pin |
| deliveredBits | output | NUM_PINS | Edge-delivered bitmap |

## Verification
Most faults in the internal service bitmap show up within one cycle at `reqValid` and `reqPin`. A lost bit hides a request that should appear one cycle after the triggering strobe. A stale bit either shows a masked or remote-gated pin, or brings back an attempt that should have been discarded. A wrong remote-pending or delivered bit is visible on its own output the cycle after the handover or end-of-interrupt. Such an error then spreads into the next level request, which either fails to appear or appears when it should be gated. Faults in the pending bit show on `irrBits` after one edge and decide whether the next edge assertion pulses `coalesced`.

// File: rtl/pin_trig_pkg.sv
`timescale 1ns/1ps
package pin_trig_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Strobes from control to datapath for the pin granted this cycle.
  typedef struct packed {
    logic fire;      // request handed over downstream
    logic accepted;  // at least one destination took it
  } svc_stb_t;

endpackage

// File: rtl/pin_trig_pick.sv
`timescale 1ns/1ps
module pin_trig_pick #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic [WIDTH-1:0] grantVec,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyGrant
);

  logic [WIDTH:0] seenBelow;
  assign seenBelow[0] = 1'b0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    assign grantVec[g]     = reqVec[g] & ~seenBelow[g];
    assign seenBelow[g+1]  = seenBelow[g] | reqVec[g];
  end

  assign anyGrant = seenBelow[WIDTH];

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (grantVec[i]) grantIdx = grantIdx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/pin_trig_datapath.sv
`timescale 1ns/1ps
module pin_trig_datapath
  import pin_trig_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int MODE_W   = 3,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lineUpd,
  input  logic [NUM_PINS-1:0] lineVal,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [VEC_W-1:0]    cfgVector,
  input  logic [DEST_W-1:0]   cfgDest,
  input  logic [MODE_W-1:0]   cfgMode,
  input  logic                cfgLevel,
  input  logic                cfgMask,
  input  logic                eoiValid,
  input  logic [VEC_W-1:0]    eoiVector,
  input  logic [NUM_PINS-1:0] grantVec,
  input  svc_stb_t            stb,
  output logic [NUM_PINS-1:0] irrBits,
  output logic [NUM_PINS-1:0] remoteBits,
  output logic [NUM_PINS-1:0] deliveredBits,
  output logic [NUM_PINS-1:0] maskBits,
  output logic [NUM_PINS-1:0] levelBits,
  output logic [NUM_PINS-1:0] eligibleBits,
  output logic [NUM_PINS-1:0] kickBits,
  output logic [NUM_PINS-1:0] dropBits,
  output logic [NUM_PINS-1:0] coalesced,
  output logic [VEC_W-1:0]    outVector,
  output logic [DEST_W-1:0]   outDest,
  output logic [MODE_W-1:0]   outMode,
  output logic                outLevel
);

  logic [VEC_W-1:0]  vecArr  [NUM_PINS];
  logic [DEST_W-1:0] destArr [NUM_PINS];
  logic [MODE_W-1:0] modeArr [NUM_PINS];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic              irrQ, remQ, delQ, mskQ;
    trig_e             trigQ;
    logic [VEC_W-1:0]  vecQ;
    logic [DEST_W-1:0] destQ;
    logic [MODE_W-1:0] modeQ;

    logic assertEv, deassertEv, cfgHit, eoiHit, fireHit, isLevel;

    assign isLevel    = (trigQ == TRIG_LEVEL);
    assign assertEv   = lineUpd[g] & lineVal[g];
    assign deassertEv = lineUpd[g] & ~lineVal[g];
    assign cfgHit     = cfgWe && (cfgIdx == IDX_W'(g));
    assign eoiHit     = eoiValid && isLevel && (vecQ == eoiVector);
    assign fireHit    = stb.fire & grantVec[g];

    // edge pins only pulse when a second assertion lands on a pending bit
    assign coalesced[g] = assertEv & ~isLevel & irrQ;

    // events that open a delivery attempt for this pin
    assign kickBits[g] = (assertEv & (isLevel | ~irrQ))
                       | (eoiHit & ~mskQ & irrQ)
                       | (cfgHit & cfgLevel & irrQ);
    assign dropBits[g] = deassertEv;

    assign eligibleBits[g] = ~mskQ & ~(isLevel & remQ);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irrQ  <= 1'b0;
        remQ  <= 1'b0;
        delQ  <= 1'b0;
        mskQ  <= 1'b1;
        trigQ <= TRIG_EDGE;
        vecQ  <= '0;
        destQ <= '0;
        modeQ <= '0;
      end else begin
        if (deassertEv)    irrQ <= 1'b0;
        else if (assertEv) irrQ <= 1'b1;

        if (fireHit && !isLevel)       delQ <= 1'b1;
        else if (assertEv && !isLevel) delQ <= 1'b0;

        if (cfgHit && !cfgLevel)                    remQ <= 1'b0;
        else if (fireHit && isLevel && stb.accepted) remQ <= 1'b1;
        else if (eoiHit)                            remQ <= 1'b0;

        if (cfgHit) begin
          mskQ  <= cfgMask;
          trigQ <= trig_e'(cfgLevel);
          vecQ  <= cfgVector;
          destQ <= cfgDest;
          modeQ <= cfgMode;
        end
      end
    end

    assign irrBits[g]       = irrQ;
    assign remoteBits[g]    = remQ;
    assign deliveredBits[g] = delQ;
    assign maskBits[g]      = mskQ;
    assign levelBits[g]     = isLevel;
    assign vecArr[g]        = vecQ;
    assign destArr[g]       = destQ;
    assign modeArr[g]       = modeQ;
  end

  // one-hot AND-OR payload select
  always_comb begin
    outVector = '0;
    outDest   = '0;
    outMode   = '0;
    outLevel  = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      outVector = outVector | (vecArr[i]  & {VEC_W{grantVec[i]}});
      outDest   = outDest   | (destArr[i] & {DEST_W{grantVec[i]}});
      outMode   = outMode   | (modeArr[i] & {MODE_W{grantVec[i]}});
      outLevel  = outLevel  | (levelBits[i] & grantVec[i]);
    end
  end

endmodule

// File: rtl/pin_trig_control.sv
`timescale 1ns/1ps
module pin_trig_control
  import pin_trig_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] kickBits,
  input  logic [NUM_PINS-1:0] dropBits,
  input  logic [NUM_PINS-1:0] eligibleBits,
  input  logic                reqReady,
  input  logic                reqAccepted,
  output logic [NUM_PINS-1:0] grantVec,
  output logic [IDX_W-1:0]    grantIdx,
  output logic                reqValid,
  output svc_stb_t            stb
);

  logic [NUM_PINS-1:0] svcQ;
  logic [NUM_PINS-1:0] candVec;
  logic [NUM_PINS-1:0] doneVec;
  logic [NUM_PINS-1:0] svcNext;
  logic                anyGrant;
  logic [IDX_W-1:0]    pickIdx;

  assign candVec = svcQ & eligibleBits;

  pin_trig_pick #(.WIDTH(NUM_PINS)) u_pick (
    .reqVec   (candVec),
    .grantVec (grantVec),
    .grantIdx (pickIdx),
    .anyGrant (anyGrant)
  );

  assign grantIdx     = pickIdx;
  assign reqValid     = anyGrant;
  assign stb.fire     = anyGrant & reqReady;
  assign stb.accepted = anyGrant & reqReady & reqAccepted;

  assign doneVec = stb.fire ? grantVec : '0;

  // ineligible attempts fall out; deassertion beats every new event
  assign svcNext = ((candVec & ~doneVec) | kickBits) & ~dropBits;

  always_ff @(posedge clk) begin
    if (!rst_n) svcQ <= '0;
    else        svcQ <= svcNext;
  end

endmodule

// File: rtl/pin_trigger_ctrl.sv
`timescale 1ns/1ps
module pin_trigger_ctrl
  import pin_trig_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int MODE_W   = 3,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lineUpd,
  input  logic [NUM_PINS-1:0] lineVal,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [VEC_W-1:0]    cfgVector,
  input  logic [DEST_W-1:0]   cfgDest,
  input  logic [MODE_W-1:0]   cfgMode,
  input  logic                cfgLevel,
  input  logic                cfgMask,
  input  logic                eoiValid,
  input  logic [VEC_W-1:0]    eoiVector,
  output logic                reqValid,
  input  logic                reqReady,
  input  logic                reqAccepted,
  output logic [IDX_W-1:0]    reqPin,
  output logic [VEC_W-1:0]    reqVector,
  output logic [DEST_W-1:0]   reqDest,
  output logic [MODE_W-1:0]   reqMode,
  output logic                reqLevel,
  output logic [NUM_PINS-1:0] coalesced,
  output logic [NUM_PINS-1:0] irrBits,
  output logic [NUM_PINS-1:0] remoteBits,
  output logic [NUM_PINS-1:0] deliveredBits
);

  logic [NUM_PINS-1:0] grantVec;
  logic [NUM_PINS-1:0] maskBits, levelBits, eligibleBits, kickBits, dropBits;
  svc_stb_t            stb;

  pin_trig_control #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .kickBits     (kickBits),
    .dropBits     (dropBits),
    .eligibleBits (eligibleBits),
    .reqReady     (reqReady),
    .reqAccepted  (reqAccepted),
    .grantVec     (grantVec),
    .grantIdx     (reqPin),
    .reqValid     (reqValid),
    .stb          (stb)
  );

  pin_trig_datapath #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W),
    .DEST_W   (DEST_W),
    .MODE_W   (MODE_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .lineUpd       (lineUpd),
    .lineVal       (lineVal),
    .cfgWe         (cfgWe),
    .cfgIdx        (cfgIdx),
    .cfgVector     (cfgVector),
    .cfgDest       (cfgDest),
    .cfgMode       (cfgMode),
    .cfgLevel      (cfgLevel),
    .cfgMask       (cfgMask),
    .eoiValid      (eoiValid),
    .eoiVector     (eoiVector),
    .grantVec      (grantVec),
    .stb           (stb),
    .irrBits       (irrBits),
    .remoteBits    (remoteBits),
    .deliveredBits (deliveredBits),
    .maskBits      (maskBits),
    .levelBits     (levelBits),
    .eligibleBits  (eligibleBits),
    .kickBits      (kickBits),
    .dropBits      (dropBits),
    .coalesced     (coalesced),
    .outVector     (reqVector),
    .outDest       (reqDest),
    .outMode       (reqMode),
    .outLevel      (reqLevel)
  );

endmodule

// File: rtl/pin_trigger_chk.sv
`timescale 1ns/1ps
module pin_trigger_chk #(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] lineUpd,
  input logic [NUM_PINS-1:0] lineVal,
  input logic                cfgWe,
  input logic                reqValid,
  input logic                reqReady,
  input logic                reqAccepted,
  input logic [IDX_W-1:0]    reqPin,
  input logic                reqLevel,
  input logic [NUM_PINS-1:0] coalesced,
  input logic [NUM_PINS-1:0] irrBits,
  input logic [NUM_PINS-1:0] remoteBits,
  input logic [NUM_PINS-1:0] deliveredBits,
  input logic [NUM_PINS-1:0] maskBits
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    AST_DEASSERT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lineUpd[g] && !lineVal[g]) |=> !irrBits[g]);  // R2
    AST_COALESCE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      coalesced[g] |=> irrBits[g]);  // R3
  end

  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> !maskBits[reqPin]);  // R4
  AST_NO_REMOTE_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqLevel) |-> !remoteBits[reqPin]);  // R4
  AST_LEVEL_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqAccepted && reqLevel && !cfgWe)
      |=> remoteBits[$past(reqPin)]);  // R5
  AST_EDGE_MARKS_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && !reqLevel) |=> deliveredBits[$past(reqPin)]);  // R9
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady && !cfgWe && !(|lineUpd)) |=> reqValid);  // R10

endmodule

bind pin_trigger_ctrl pin_trigger_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lineUpd       (lineUpd),
  .lineVal       (lineVal),
  .cfgWe         (cfgWe),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .reqAccepted   (reqAccepted),
  .reqPin        (reqPin),
  .reqLevel      (reqLevel),
  .coalesced     (coalesced),
  .irrBits       (irrBits),
  .remoteBits    (remoteBits),
  .deliveredBits (deliveredBits),
  .maskBits      (maskBits)
);

// File: tb/sim_pin_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_pin_trigger_ctrl;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] lineUpd, lineVal;
  logic          cfgWe;
  logic [2:0]    cfgIdx;
  logic [7:0]    cfgVector, cfgDest;
  logic [2:0]    cfgMode;
  logic          cfgLevel, cfgMask;
  logic          eoiValid;
  logic [7:0]    eoiVector;
  logic          reqValid, reqReady, reqAccepted;
  logic [2:0]    reqPin;
  logic [7:0]    reqVector, reqDest;
  logic [2:0]    reqMode;
  logic          reqLevel;
  logic [NP-1:0] coalesced, irrBits, remoteBits, deliveredBits;

  always #10 clk = ~clk;

  pin_trigger_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lineUpd(lineUpd), .lineVal(lineVal),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgVector(cfgVector), .cfgDest(cfgDest),
    .cfgMode(cfgMode), .cfgLevel(cfgLevel), .cfgMask(cfgMask),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .reqValid(reqValid), .reqReady(reqReady), .reqAccepted(reqAccepted),
    .reqPin(reqPin), .reqVector(reqVector), .reqDest(reqDest), .reqMode(reqMode),
    .reqLevel(reqLevel), .coalesced(coalesced), .irrBits(irrBits),
    .remoteBits(remoteBits), .deliveredBits(deliveredBits)
  );

  localparam logic [2:0] OP_CFG = 3'd0, OP_AS = 3'd1, OP_DE = 3'd2,
                         OP_EOI = 3'd3, OP_ACK = 3'd4, OP_IDLE = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] pin;
    logic       lvl;
    logic       msk;
    logic [7:0] vec;
    logic       acc;
    logic       eValid;
    logic [2:0] ePin;
    logic [7:0] eIrr;
    logic [7:0] eRem;
    logic [7:0] eDel;
    logic       eCoal;
  } row_t;

  localparam int NROWS = 43;
  localparam row_t TBL [NROWS] = '{
    //  op      pin  lvl  msk  vec    acc  val  pin   irr    rem    del    coal
    '{OP_CFG,  3'd0,1'b0,1'b0,8'h30,1'b0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0},
    '{OP_CFG,  3'd1,1'b1,1'b0,8'h31,1'b0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0},
    '{OP_CFG,  3'd2,1'b0,1'b1,8'h32,1'b0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0},
    '{OP_AS,   3'd0,1'b0,1'b0,8'h00,1'b0,1'b1,3'd0,8'h01,8'h00,8'h00,1'b0}, // R3 first edge
    '{OP_AS,   3'd0,1'b0,1'b0,8'h00,1'b0,1'b1,3'd0,8'h01,8'h00,8'h00,1'b1}, // R3 coalesced
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b1,1'b0,3'd0,8'h01,8'h00,8'h01,1'b0}, // R9 mark
    '{OP_AS,   3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h01,8'h00,8'h00,1'b1}, // R9 clear, R3
    '{OP_DE,   3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0}, // R2
    '{OP_AS,   3'd0,1'b0,1'b0,8'h00,1'b0,1'b1,3'd0,8'h01,8'h00,8'h00,1'b0},
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h01,8'h00,8'h01,1'b0},
    '{OP_DE,   3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00,8'h00,8'h01,1'b0},
    '{OP_AS,   3'd2,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h04,8'h00,8'h01,1'b0}, // R4 masked
    '{OP_CFG,  3'd2,1'b0,1'b0,8'h32,1'b0,1'b0,3'd0,8'h04,8'h00,8'h01,1'b0}, // R4 no retry
    '{OP_AS,   3'd2,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h04,8'h00,8'h01,1'b1},
    '{OP_DE,   3'd2,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00,8'h00,8'h01,1'b0},
    '{OP_AS,   3'd1,1'b0,1'b0,8'h00,1'b0,1'b1,3'd1,8'h02,8'h00,8'h01,1'b0},
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h02,8'h00,8'h01,1'b0}, // R5 not accepted
    '{OP_AS,   3'd1,1'b0,1'b0,8'h00,1'b0,1'b1,3'd1,8'h02,8'h00,8'h01,1'b0},
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b1,1'b0,3'd0,8'h02,8'h02,8'h01,1'b0}, // R5 accepted
    '{OP_AS,   3'd1,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h02,8'h02,8'h01,1'b0}, // R4 remote gate
    '{OP_IDLE, 3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h02,8'h02,8'h01,1'b0},
    '{OP_EOI,  3'd0,1'b0,1'b0,8'h55,1'b0,1'b0,3'd0,8'h02,8'h02,8'h01,1'b0}, // R6 no match
    '{OP_EOI,  3'd0,1'b0,1'b0,8'h30,1'b0,1'b0,3'd0,8'h02,8'h02,8'h01,1'b0}, // R6 edge match
    '{OP_EOI,  3'd0,1'b0,1'b0,8'h31,1'b0,1'b1,3'd1,8'h02,8'h00,8'h01,1'b0}, // R6, R7 redeliver
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b1,1'b0,3'd0,8'h02,8'h02,8'h01,1'b0},
    '{OP_DE,   3'd1,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00,8'h02,8'h01,1'b0},
    '{OP_EOI,  3'd0,1'b0,1'b0,8'h31,1'b0,1'b0,3'd0,8'h00,8'h00,8'h01,1'b0}, // R7 no pending
    '{OP_AS,   3'd3,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h08,8'h00,8'h01,1'b0},
    '{OP_IDLE, 3'd0,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h08,8'h00,8'h01,1'b0},
    '{OP_CFG,  3'd3,1'b1,1'b0,8'h33,1'b0,1'b1,3'd3,8'h08,8'h00,8'h01,1'b0}, // R8 level kick
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b1,1'b0,3'd0,8'h08,8'h08,8'h01,1'b0},
    '{OP_CFG,  3'd3,1'b0,1'b0,8'h33,1'b0,1'b0,3'd0,8'h08,8'h00,8'h01,1'b0}, // R8 edge clears
    '{OP_DE,   3'd3,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00,8'h00,8'h01,1'b0},
    '{OP_CFG,  3'd5,1'b0,1'b0,8'h35,1'b0,1'b0,3'd0,8'h00,8'h00,8'h01,1'b0},
    '{OP_CFG,  3'd4,1'b0,1'b0,8'h34,1'b0,1'b0,3'd0,8'h00,8'h00,8'h01,1'b0},
    '{OP_AS,   3'd5,1'b0,1'b0,8'h00,1'b0,1'b1,3'd5,8'h20,8'h00,8'h01,1'b0},
    '{OP_AS,   3'd4,1'b0,1'b0,8'h00,1'b0,1'b1,3'd4,8'h30,8'h00,8'h01,1'b0}, // R10 lowest
    '{OP_IDLE, 3'd0,1'b0,1'b0,8'h00,1'b0,1'b1,3'd4,8'h30,8'h00,8'h01,1'b0}, // R10 held
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b1,1'b1,3'd5,8'h30,8'h00,8'h11,1'b0},
    '{OP_ACK,  3'd0,1'b0,1'b0,8'h00,1'b1,1'b0,3'd0,8'h30,8'h00,8'h31,1'b0},
    '{OP_CFG,  3'd6,1'b0,1'b0,8'h36,1'b0,1'b0,3'd0,8'h30,8'h00,8'h31,1'b0},
    '{OP_AS,   3'd6,1'b0,1'b0,8'h00,1'b0,1'b1,3'd6,8'h70,8'h00,8'h31,1'b0},
    '{OP_DE,   3'd6,1'b0,1'b0,8'h00,1'b0,1'b0,3'd0,8'h30,8'h00,8'h31,1'b0}  // R2 cancel
  };

  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;
  logic [7:0] shVec [NP];
  logic       shLvl [NP];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    lineUpd = '0; lineVal = '0; cfgWe = 1'b0; cfgIdx = '0; cfgVector = '0;
    cfgDest = '0; cfgMode = '0; cfgLevel = 1'b0; cfgMask = 1'b1;
    eoiValid = 1'b0; eoiVector = '0; reqReady = 1'b0; reqAccepted = 1'b0;
  endtask

  task automatic driveRow(input row_t r);
    case (r.op)
      OP_CFG: begin
        cfgWe = 1'b1; cfgIdx = r.pin; cfgVector = r.vec; cfgDest = 8'h10 + 8'(r.pin);
        cfgMode = r.pin; cfgLevel = r.lvl; cfgMask = r.msk;
        shVec[r.pin] = r.vec; shLvl[r.pin] = r.lvl;
      end
      OP_AS:  begin lineUpd[r.pin] = 1'b1; lineVal[r.pin] = 1'b1; end
      OP_DE:  begin lineUpd[r.pin] = 1'b1; lineVal[r.pin] = 1'b0; end
      OP_EOI: begin eoiValid = 1'b1; eoiVector = r.vec; end
      OP_ACK: begin reqReady = 1'b1; reqAccepted = r.acc; end
      default: ;
    endcase
  endtask

  task automatic checkState(input row_t r, input int idx);
    string tag;
    tag = $sformatf("row%0d", idx);
    chk(reqValid == r.eValid, "R10", {tag, " reqValid"}, reqValid, r.eValid);
    if (r.eValid && reqValid) begin
      chk(reqPin == r.ePin, "R10", {tag, " reqPin"}, reqPin, r.ePin);
      chk(reqVector == shVec[r.ePin], "R11", {tag, " reqVector"}, reqVector, shVec[r.ePin]);
      chk(reqDest == 8'h10 + 8'(r.ePin), "R11", {tag, " reqDest"}, reqDest, 8'h10 + r.ePin);
      chk(reqMode == r.ePin, "R11", {tag, " reqMode"}, reqMode, r.ePin);
      chk(reqLevel == shLvl[r.ePin], "R11", {tag, " reqLevel"}, reqLevel, shLvl[r.ePin]);
    end
    chk(irrBits == r.eIrr, "R2", {tag, " irrBits"}, irrBits, r.eIrr);
    chk(remoteBits == r.eRem, "R5", {tag, " remoteBits"}, remoteBits, r.eRem);
    chk(deliveredBits == r.eDel, "R9", {tag, " deliveredBits"}, deliveredBits, r.eDel);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin shVec[i] = '0; shLvl[i] = 1'b0; end
    idleInputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(reqValid == 1'b0, "R1", "reset reqValid", reqValid, 0);
    chk(irrBits == '0, "R1", "reset irrBits", irrBits, 0);
    chk(remoteBits == '0, "R1", "reset remoteBits", remoteBits, 0);
    chk(deliveredBits == '0, "R1", "reset deliveredBits", deliveredBits, 0);

    for (int k = 0; k < NROWS; k++) begin
      driveRow(TBL[k]);
      #1;
      chk(coalesced == (NP'(TBL[k].eCoal) << TBL[k].pin), "R3",
          $sformatf("row%0d coalesced", k + 1), coalesced, NP'(TBL[k].eCoal) << TBL[k].pin);
      @(negedge clk);
      idleInputs();
      #1;
      checkState(TBL[k], k + 1);
    end

    // R1 mid-run reset: entries return to masked, bitmaps clear
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(reqValid == 1'b0, "R1", "rereset reqValid", reqValid, 0);
    chk(irrBits == '0 && remoteBits == '0 && deliveredBits == '0, "R1",
        "rereset bitmaps", {irrBits, remoteBits, deliveredBits}, 0);
    lineUpd[0] = 1'b1; lineVal[0] = 1'b1;
    #1;
    chk(coalesced == '0, "R1", "rereset coalesced", coalesced, 0);
    @(negedge clk);
    idleInputs();
    #1;
    chk(irrBits == 8'h01, "R1", "rereset irr after assert", irrBits, 8'h01);
    chk(reqValid == 1'b0, "R1", "rereset masked pin no request", reqValid, 0);
    @(negedge clk);
    #1;
    chk(reqValid == 1'b0, "R4", "discarded masked attempt", reqValid, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule